// File: doc/BRIEF.md
# Configurable Round and Saturate Unit

This block is the output stage of a signed accumulator path. It takes a 44-bit two's-complement word and rounds it to a chosen bit position. It then clamps the result so that it fits a chosen signed width and returns the result sign-extended to 44 bits. The result leaves a register one cycle after the input, with a valid flag and a flag that marks each word that was clamped.

Configuration inputs are static and are changed only while no data is flowing:

- **Rounding enable.**
- **Rounding selector.** Picks the LSB position 6 to 21.
- **Saturation selector.** Picks the top (sign) position 28 to 43.
- **Style bit.**
  - **Asymmetric style** uses the full two's-complement range.
  - **Symmetric style** keeps the negative limit one result LSB above the most negative code, so the range is balanced about zero.

The result LSB is the rounding position when rounding is enabled. It is bit 0 when rounding is disabled.

Top module: `rsat_unit`

## Requirements
- R1: After reset, `out_data` is zero and `out_vld` and `out_ovf` are low. A word presented with `in_vld` high appears on the outputs, with `out_vld` high, after exactly one rising clock edge. Back-to-back words stream with no gaps.
- R2: On a cycle when `in_vld` is low, the next cycle has `out_vld` low and `out_ovf` low, and `out_data` keeps its previous value.
- R3: With `rnd_en` high, the result LSB position is L = 6 + `rnd_sel`. The unit adds 2^(L-1) to the input, then clears bits [L-1:0]. Ties therefore round toward positive infinity, for negative values as well.
- R4: With `rnd_en` low, no rounding takes place, and the result LSB is bit 0.
- R5: The top position is T = 28 + `sat_sel`, so the result width is T+1 bits. When bits 44..T of the rounded value (held with one guard bit) are all equal, the rounded value is output unchanged and `out_ovf` is low. The exception is the case in R8.
- R6: With `sym_mode` low, a positive value out of range produces bits [T-1:L] set and all other bits clear, with `out_ovf` high. A negative value out of range produces -2^T sign-extended, with `out_ovf` high.
- R7: With `sym_mode` high, the positive limit is as in R6. A negative value out of range produces -2^T + 2^L, with `out_ovf` high.
- R8: With `sym_mode` high, a rounded value equal to -2^T is replaced by -2^T + 2^L, and `out_ovf` is high. With `sym_mode` low, the same value passes through with `out_ovf` low.
- R9: A carry that rounding produces is never lost to wrap-around. If it lifts the value past the positive limit, the result is the positive limit with `out_ovf` high. A value that lands exactly on the limit passes with `out_ovf` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_data | input | 44 | Two's-complement accumulator word |
| in_vld | input | 1 | `in_data` is valid this cycle |
| rnd_en | input | 1 | Enables rounding (static) |
| rnd_sel | input | 4 | Rounding position select, LSB = 6 + value (static) |
| sat_sel | input | 4 | Saturation top select, top = 28 + value (static) |
| sym_mode | input | 1 | 1 = symmetric limits, 0 = asymmetric limits (static) |
| out_data | output | 44 | Rounded and clamped word, sign-extended |
| out_vld | output | 1 | `out_data` holds a new result |
| out_ovf | output | 1 | The current result was clamped |

## Verification
The case hardest to reach is a value that lands exactly on the most negative code in symmetric style. It is in range for asymmetric style, yet it must be clamped. The stimulus reaches this code in two ways: directly with rounding off, and indirectly through rounding an input that is half an LSB below it.

The same input is replayed with only the style bit flipped, so the bench sees both outcomes. The bench also drives inputs that land exactly on the positive limit and inputs one tie above it, so that a carry from rounding either stays in range or crosses the limit.

// File: rtl/rsat_pkg.sv
package rsat_pkg;

    localparam int RSAT_DATA_W = 44;

    typedef struct packed {
        logic [RSAT_DATA_W-1:0] data;
        logic                   vld;
        logic                   ovf;
    } rsat_out_t;

endpackage

// File: rtl/rsat_round.sv
module rsat_round #(
    parameter int DATA_W   = 44,
    parameter int SEL_W    = 4,
    parameter int RND_BASE = 6,
    parameter int POS_W    = 6
) (
    input  logic [DATA_W-1:0] din,
    input  logic              rnd_en,
    input  logic [SEL_W-1:0]  rnd_sel,
    output logic [DATA_W:0]   rnd_val,
    output logic [POS_W-1:0]  lsb_pos
);

    localparam int EXT_W = DATA_W + 1;

    logic [EXT_W-1:0] ext_d;
    logic [EXT_W-1:0] half_d;
    logic [EXT_W-1:0] sum_d;

    always_comb begin
        lsb_pos = rnd_en ? (POS_W'(RND_BASE) + POS_W'(rnd_sel)) : '0;
        ext_d   = {din[DATA_W-1], din};
        half_d  = '0;
        if (rnd_en) begin
            half_d = EXT_W'(1) << (lsb_pos - POS_W'(1));
        end
        sum_d = ext_d + half_d;
        for (int i = 0; i < EXT_W; i++) begin
            rnd_val[i] = sum_d[i] & (!rnd_en || (i >= int'(lsb_pos)));
        end
    end

endmodule

// File: rtl/rsat_clamp.sv
module rsat_clamp #(
    parameter int DATA_W   = 44,
    parameter int SEL_W    = 4,
    parameter int SAT_BASE = 28,
    parameter int POS_W    = 6
) (
    input  logic [DATA_W:0]   rnd_val,
    input  logic [SEL_W-1:0]  sat_sel,
    input  logic              sym_mode,
    input  logic [POS_W-1:0]  lsb_pos,
    output logic [DATA_W-1:0] dout,
    output logic              ovf
);

    logic [POS_W-1:0]  top_pos;
    logic              hi_one_d;
    logic              hi_zero_d;
    logic              lo_zero_d;
    logic              floor_hit_d;
    logic [DATA_W-1:0] pos_lim_d;
    logic [DATA_W-1:0] neg_lim_d;

    always_comb begin
        top_pos   = POS_W'(SAT_BASE) + POS_W'(sat_sel);
        hi_one_d  = 1'b1;
        hi_zero_d = 1'b1;
        lo_zero_d = 1'b1;
        for (int i = 0; i <= DATA_W; i++) begin
            if (i >= int'(top_pos)) begin
                hi_one_d  = hi_one_d & rnd_val[i];
                hi_zero_d = hi_zero_d & !rnd_val[i];
            end else begin
                lo_zero_d = lo_zero_d & !rnd_val[i];
            end
        end
        floor_hit_d = sym_mode && hi_one_d && lo_zero_d;
        ovf         = !(hi_one_d || hi_zero_d) || floor_hit_d;

        for (int i = 0; i < DATA_W; i++) begin
            pos_lim_d[i] = (i < int'(top_pos)) && (i >= int'(lsb_pos));
            neg_lim_d[i] = (i >= int'(top_pos)) || (sym_mode && (i == int'(lsb_pos)));
        end

        if (!ovf) begin
            dout = rnd_val[DATA_W-1:0];
        end else if (rnd_val[DATA_W]) begin
            dout = neg_lim_d;
        end else begin
            dout = pos_lim_d;
        end
    end

endmodule

// File: rtl/rsat_unit.sv
module rsat_unit
    import rsat_pkg::*;
#(
    parameter int DATA_W   = RSAT_DATA_W,
    parameter int SEL_W    = 4,
    parameter int RND_BASE = 6,
    parameter int SAT_BASE = 28
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_vld,
    input  logic              rnd_en,
    input  logic [SEL_W-1:0]  rnd_sel,
    input  logic [SEL_W-1:0]  sat_sel,
    input  logic              sym_mode,
    output logic [DATA_W-1:0] out_data,
    output logic              out_vld,
    output logic              out_ovf
);

    localparam int EXT_W = DATA_W + 1;
    localparam int POS_W = $clog2(EXT_W + 1);

    logic [EXT_W-1:0]  rnd_val;
    logic [POS_W-1:0]  lsb_pos;
    logic [DATA_W-1:0] clamp_dout;
    logic              clamp_ovf;

    rsat_out_t state_d, state_q;

    rsat_round #(
        .DATA_W(DATA_W), .SEL_W(SEL_W), .RND_BASE(RND_BASE), .POS_W(POS_W)
    ) u_round (
        .din(in_data), .rnd_en(rnd_en), .rnd_sel(rnd_sel),
        .rnd_val(rnd_val), .lsb_pos(lsb_pos)
    );

    rsat_clamp #(
        .DATA_W(DATA_W), .SEL_W(SEL_W), .SAT_BASE(SAT_BASE), .POS_W(POS_W)
    ) u_clamp (
        .rnd_val(rnd_val), .sat_sel(sat_sel), .sym_mode(sym_mode),
        .lsb_pos(lsb_pos), .dout(clamp_dout), .ovf(clamp_ovf)
    );

    always_comb begin
        state_d     = state_q;
        state_d.vld = in_vld;
        state_d.ovf = in_vld & clamp_ovf;
        if (in_vld) begin
            state_d.data = clamp_dout;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign out_data = state_q.data;
    assign out_vld  = state_q.vld;
    assign out_ovf  = state_q.ovf;

    // Checker-only copies of the configuration that belongs to the word on the outputs
    logic             chk_ren_q;
    logic             chk_sym_q;
    logic [POS_W-1:0] chk_lsb_q;
    logic [POS_W-1:0] chk_top_q;
    logic             chk_fit;
    logic             chk_low_zero;
    logic             chk_floor;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chk_ren_q <= 1'b0;
            chk_sym_q <= 1'b0;
            chk_lsb_q <= '0;
            chk_top_q <= POS_W'(DATA_W - 1);
        end else if (in_vld) begin
            chk_ren_q <= rnd_en;
            chk_sym_q <= sym_mode;
            chk_lsb_q <= POS_W'(RND_BASE) + POS_W'(rnd_sel);
            chk_top_q <= POS_W'(SAT_BASE) + POS_W'(sat_sel);
        end
    end

    always_comb begin
        chk_fit      = 1'b1;
        chk_low_zero = 1'b1;
        chk_floor    = 1'b1;
        for (int i = 0; i < DATA_W; i++) begin
            if (i >= int'(chk_top_q)) begin
                chk_fit   = chk_fit & (out_data[i] == out_data[DATA_W-1]);
                chk_floor = chk_floor & out_data[i];
            end else begin
                chk_floor = chk_floor & !out_data[i];
            end
            if (i < int'(chk_lsb_q)) begin
                chk_low_zero = chk_low_zero & !out_data[i];
            end
        end
    end

    // R1
    vld_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_vld |=> out_vld);

    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_vld |=> (!out_vld && !out_ovf && $stable(out_data)));

    // R5
    width_fit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_vld |-> chk_fit);

    // R3
    round_lsb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_vld && chk_ren_q) |-> chk_low_zero);

    // R8
    sym_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_vld && chk_sym_q) |-> !chk_floor);

endmodule

// File: tb/rsat_unit_test.sv
module rsat_unit_test;

    typedef struct packed {
        logic [43:0] din;
        logic        ren;
        logic [3:0]  rsel;
        logic [3:0]  ssel;
        logic        sym;
        logic [43:0] exp;
        logic        eovf;
        int          req;
    } vec_t;

    localparam int NV = 24;
    localparam vec_t VECS [NV] = '{
        // R5: in range, no rounding, widest result
        '{44'h00000001234, 1'b0, 4'd0,  4'd15, 1'b0, 44'h00000001234, 1'b0, 5},
        // R3: LSB at bit 6, round up, exact tie up, below tie down
        '{44'h0000000003F, 1'b1, 4'd0,  4'd15, 1'b0, 44'h00000000040, 1'b0, 3},
        '{44'h00000000020, 1'b1, 4'd0,  4'd15, 1'b0, 44'h00000000040, 1'b0, 3},
        '{44'h0000000001F, 1'b1, 4'd0,  4'd15, 1'b0, 44'h00000000000, 1'b0, 3},
        // R3: negative tie goes up, negative past tie goes down
        '{44'hFFFFFFFFFE0, 1'b1, 4'd0,  4'd15, 1'b0, 44'h00000000000, 1'b0, 3},
        '{44'hFFFFFFFFFDF, 1'b1, 4'd0,  4'd15, 1'b0, 44'hFFFFFFFFFC0, 1'b0, 3},
        // R3: LSB at bit 21
        '{44'h00000100000, 1'b1, 4'd15, 4'd15, 1'b0, 44'h00000200000, 1'b0, 3},
        '{44'h000000FFFFF, 1'b1, 4'd15, 4'd15, 1'b0, 44'h00000000000, 1'b0, 3},
        // R6 / R7: 36-bit result, positive and negative overflow, both styles
        '{44'h5926AC01342, 1'b0, 4'd0,  4'd7,  1'b0, 44'h007FFFFFFFF, 1'b1, 6},
        '{44'h5926AC01342, 1'b0, 4'd0,  4'd7,  1'b1, 44'h007FFFFFFFF, 1'b1, 7},
        '{44'hFADA38D2210, 1'b0, 4'd0,  4'd7,  1'b0, 44'hFF800000000, 1'b1, 6},
        '{44'hFADA38D2210, 1'b0, 4'd0,  4'd7,  1'b1, 44'hFF800000001, 1'b1, 7},
        // R7 / R6: 29-bit result with LSB at bit 6
        '{44'h80000000000, 1'b1, 4'd0,  4'd0,  1'b1, 44'hFFFF0000040, 1'b1, 7},
        '{44'h80000000000, 1'b1, 4'd0,  4'd0,  1'b0, 44'hFFFF0000000, 1'b1, 6},
        '{44'h7FFFFFFFFFF, 1'b1, 4'd0,  4'd0,  1'b0, 44'h0000FFFFFC0, 1'b1, 6},
        // R8: value exactly on the most negative code
        '{44'hFFFF0000000, 1'b0, 4'd0,  4'd0,  1'b1, 44'hFFFF0000001, 1'b1, 8},
        '{44'hFFFF0000000, 1'b0, 4'd0,  4'd0,  1'b0, 44'hFFFF0000000, 1'b0, 8},
        '{44'hFFFEFFFFFE0, 1'b1, 4'd0,  4'd0,  1'b1, 44'hFFFF0000040, 1'b1, 8},
        '{44'h80000000000, 1'b0, 4'd0,  4'd15, 1'b1, 44'h80000000001, 1'b1, 8},
        '{44'h80000000000, 1'b0, 4'd0,  4'd15, 1'b0, 44'h80000000000, 1'b0, 8},
        // R9: rounding carry past the limit, landing on the limit
        '{44'h7FFFFFFFFFF, 1'b1, 4'd0,  4'd15, 1'b0, 44'h7FFFFFFFFC0, 1'b1, 9},
        '{44'h0000FFFFFA0, 1'b1, 4'd0,  4'd0,  1'b0, 44'h0000FFFFFC0, 1'b0, 9},
        '{44'h0000FFFFFE0, 1'b1, 4'd0,  4'd0,  1'b0, 44'h0000FFFFFC0, 1'b1, 9},
        // R4: rounding disabled keeps low bits
        '{44'h0000000003F, 1'b0, 4'd3,  4'd15, 1'b0, 44'h0000000003F, 1'b0, 4}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [43:0] in_data = '0;
    logic        in_vld = 1'b0;
    logic        rnd_en = 1'b0;
    logic [3:0]  rnd_sel = '0;
    logic [3:0]  sat_sel = '0;
    logic        sym_mode = 1'b0;
    logic [43:0] out_data;
    logic        out_vld;
    logic        out_ovf;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    rsat_unit uut (
        .clk(clk), .rst_n(rst_n), .in_data(in_data), .in_vld(in_vld),
        .rnd_en(rnd_en), .rnd_sel(rnd_sel), .sat_sel(sat_sel), .sym_mode(sym_mode),
        .out_data(out_data), .out_vld(out_vld), .out_ovf(out_ovf)
    );

    task automatic check(input int req, input string what,
                         input logic [43:0] got, input logic [43:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL R%0d %s: got %h expected %h", req, what, got, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        logic [43:0] held;
        repeat (3) @(negedge clk);
        // R1: reset state
        check(1, "reset data", out_data, 44'h0);
        check(1, "reset vld", 44'(out_vld), 44'h0);
        check(1, "reset ovf", 44'(out_ovf), 44'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // Table walk: back-to-back stream, one-edge latency (R1)
        for (int k = 0; k < NV; k++) begin
            in_data  = VECS[k].din;
            rnd_en   = VECS[k].ren;
            rnd_sel  = VECS[k].rsel;
            sat_sel  = VECS[k].ssel;
            sym_mode = VECS[k].sym;
            in_vld   = 1'b1;
            @(negedge clk);
            check(1, "stream vld", 44'(out_vld), 44'h1);
            check(VECS[k].req, "data", out_data, VECS[k].exp);
            check(VECS[k].req, "ovf", 44'(out_ovf), 44'(VECS[k].eovf));
        end

        // R2: overflowing word, then idle with different data
        in_data = 44'h5926AC01342; rnd_en = 1'b0; sat_sel = 4'd7; sym_mode = 1'b0;
        @(negedge clk);
        held = out_data;
        check(6, "pre-idle ovf", 44'(out_ovf), 44'h1);
        in_vld  = 1'b0;
        in_data = 44'h00000000001;
        @(negedge clk);
        check(2, "idle vld", 44'(out_vld), 44'h0);
        check(2, "idle ovf", 44'(out_ovf), 44'h0);
        check(2, "idle data", out_data, held);
        @(negedge clk);
        check(2, "idle data later", out_data, held);

        // R1: valid again after a gap
        in_vld = 1'b1;
        @(negedge clk);
        check(1, "resume vld", 44'(out_vld), 44'h1);
        check(5, "resume data", out_data, 44'h00000000001);
        in_vld = 1'b0;

        // R1: reset mid-stream clears outputs
        rst_n = 1'b0;
        @(negedge clk);
        check(1, "re-reset data", out_data, 44'h0);
        check(1, "re-reset vld", 44'(out_vld), 44'h0);
        rst_n = 1'b1;
        @(negedge clk);
        finish_run();
    end

endmodule